// File: doc/BRIEF.md
# Descriptor Checksum Unit

This block computes, or verifies, the one-byte integrity checksum of a sixteen-byte transfer descriptor while the bytes stream past it. The bytes arrive one per accepted beat, lowest address first. A `last` flag marks the final byte. The unit does not fetch anything from memory: the surrounding logic feeds it bytes and reads its one-cycle result pulse.

The checksum is built as follows. The byte at offset 1 is the checksum's own slot, so it is treated as zero. The other fifteen bytes are added modulo 256, and a constant 1 is added for an ownership bit that is taken as set. The value to store is 0xFF minus that sum.

The unit has two modes. In generate mode it outputs the value that should be written into the slot. In check mode it also compares that value with the byte actually carried in the slot and reports pass or fail. A descriptor whose `last` does not arrive on the sixteenth byte produces a framing error pulse in place of a result.

Top module: `desc_csum_unit`

## Requirements
- R1: A descriptor is 16 beats with `in_valid` high, and `in_last` is high on the sixteenth. A result (`out_valid` or `out_frame_err`) pulses for exactly one cycle, in the cycle after the beat that carries `in_last`, and at no other time.
- R2: The byte at offset 1 (the second beat) contributes zero to the sum, whatever its value.
- R3: The fifteen remaining bytes are summed modulo 256.
- R4: A constant 1 is added to the sum, whatever bit 0 of the byte at offset 0 holds.
- R5: `out_csum` equals 0xFF minus the final 8-bit sum, when `out_valid` is high.
- R6: `in_mode` is sampled on the first beat of a descriptor and ignored on later beats: 0 selects generate, 1 selects check. In generate mode `out_pass` stays 0.
- R7: In check mode, `out_pass` is 1 exactly when the byte received at offset 1 equals the computed checksum.
- R8: If `in_last` arrives on beat 1 to 15, `out_frame_err` pulses one cycle later and `out_valid` stays low.
- R9: If the sixteenth beat has no `in_last`, further bytes are discarded up to the beat with `in_last`. `out_frame_err` pulses one cycle after that beat and `out_valid` stays low.
- R10: Every beat with `in_last` ends the descriptor and clears the running state, so the next descriptor may start on the very next cycle and is computed correctly.
- R11: After reset, `out_valid`, `out_frame_err`, `out_pass` and `out_csum` are all 0.
- R12: Cycles with `in_valid` low are ignored, including idle gaps inside a descriptor. While no result is pulsing, `out_csum` and `out_pass` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat valid |
| in_last | input | 1 | Final byte of descriptor |
| in_data | input | 8 | Descriptor byte |
| in_mode | input | 1 | 0 generate, 1 check (sampled on first beat) |
| out_valid | output | 1 | Result pulse for a well-framed descriptor |
| out_csum | output | 8 | Computed checksum |
| out_pass | output | 1 | Check mode: stored byte matched |
| out_frame_err | output | 1 | Framing error pulse |

## Verification
The assertions check on every cycle the properties that hold regardless of data:
- the one-cycle result timing relative to `last`;
- mutual exclusion of a result and a framing error;
- `out_pass` never rising without `out_valid`, or in generate mode;
- the beat counter returning to the first position after every `last`;
- the accumulator holding through idle cycles.

The arithmetic can only be shown by the bench's scenarios, which compare against a sum computed independently. These scenarios cover:
- masking of the offset-1 byte;
- the added one and modulo wrap;
- the comparison result at every possible slot value;
- the handling of short, long and back-to-back descriptors.

// File: rtl/desc_csum_pkg.sv
package desc_csum_pkg;

  // Operating mode, captured on the first byte of each descriptor.
  typedef enum logic {
    CSUM_GEN = 1'b0,
    CSUM_CHK = 1'b1
  } csum_mode_e;

endpackage

// File: rtl/desc_beat_counter.sv
// Tracks the byte position inside the current descriptor and detects framing.
module desc_beat_counter #(
  parameter int NUM_BYTES = 16,
  parameter int CW        = $clog2(NUM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic          beat_last,
  output logic [CW-1:0] beat_idx,
  output logic          beat_first,
  output logic          beat_in_frame,
  output logic          frame_good,
  output logic          frame_bad
);

  localparam logic [CW-1:0] LAST_IDX = CW'(NUM_BYTES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          cnt_en;

  assign beat_idx      = cnt_q;
  assign beat_in_frame = !ovr_q;
  assign beat_first    = (cnt_q == '0) && !ovr_q;
  assign frame_good    = beat_valid && beat_last && (cnt_q == LAST_IDX) && !ovr_q;
  assign frame_bad     = beat_valid && beat_last && !((cnt_q == LAST_IDX) && !ovr_q);

  assign cnt_en = beat_valid;

  always_comb begin
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (beat_last) begin
      cnt_d = '0;
      ovr_d = 1'b0;
    end else if (ovr_q || (cnt_q == LAST_IDX)) begin
      ovr_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  // R10: every terminating beat returns the counter to the first position
  p_restart_after_last_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |=> beat_first);

  // R9: once overrun is entered the counter stays parked on the final index
  p_overrun_parked_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !beat_in_frame |-> (beat_idx == LAST_IDX));

endmodule

// File: rtl/desc_sum_accum.sv
// Masked modulo accumulator plus capture of the slot byte and the mode.
module desc_sum_accum
  import desc_csum_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int CSUM_OFFSET = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic          beat_first,
  input  logic          beat_in_frame,
  input  logic [CW-1:0] beat_idx,
  input  logic [DW-1:0] beat_data,
  input  csum_mode_e    beat_mode,
  output logic [DW-1:0] sum_total,
  output logic [DW-1:0] slot_byte,
  output csum_mode_e    mode_eff
);

  localparam logic [CW-1:0] SLOT_IDX = CW'(CSUM_OFFSET);

  logic [DW-1:0] sum_q, sum_d;
  logic [DW-1:0] slot_q, slot_d;
  csum_mode_e    mode_q, mode_d;
  logic [DW-1:0] contrib;
  logic          is_slot;
  logic          acc_en;

  assign acc_en  = beat_valid;
  assign is_slot = beat_in_frame && (beat_idx == SLOT_IDX);

  // Slot byte and discarded overrun bytes add nothing.
  always_comb begin
    if (!beat_in_frame || is_slot) contrib = '0;
    else                           contrib = beat_data;
  end

  always_comb begin
    sum_d  = (beat_first ? '0 : sum_q) + contrib;
    slot_d = is_slot ? beat_data : slot_q;
    mode_d = beat_first ? beat_mode : mode_q;
  end

  assign sum_total = sum_d;
  assign slot_byte = slot_d;
  assign mode_eff  = mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      slot_q <= '0;
      mode_q <= CSUM_GEN;
    end else if (acc_en) begin
      sum_q  <= sum_d;
      slot_q <= slot_d;
      mode_q <= mode_d;
    end
  end

  // R12: idle cycles leave the running sum untouched
  p_idle_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |=> $stable(sum_q));

  // R6: the captured mode cannot change except on a first beat
  p_mode_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_first) |=> $stable(mode_q));

endmodule

// File: rtl/desc_result_stage.sv
// Final complement, comparison and one-cycle result register.
module desc_result_stage
  import desc_csum_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_valid,
  input  logic          frame_good,
  input  logic          frame_bad,
  input  logic [DW-1:0] sum_total,
  input  logic [DW-1:0] slot_byte,
  input  csum_mode_e    mode_eff,
  output logic          res_valid,
  output logic [DW-1:0] res_csum,
  output logic          res_pass,
  output logic          res_err
);

  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
  localparam logic [DW-1:0] OWN_BIT  = DW'(1);

  logic [DW-1:0] csum_calc;
  logic          v_d, v_q, e_d, e_q, p_d, p_q;
  logic [DW-1:0] c_d, c_q;

  assign csum_calc = ALL_ONES - (sum_total + OWN_BIT);

  always_comb begin
    v_d = 1'b0;
    e_d = 1'b0;
    p_d = 1'b0;
    c_d = '0;
    if (fin_valid && frame_good) begin
      v_d = 1'b1;
      c_d = csum_calc;
      p_d = (mode_eff == CSUM_CHK) && (slot_byte == csum_calc);
    end else if (fin_valid && frame_bad) begin
      e_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      e_q <= 1'b0;
      p_q <= 1'b0;
      c_q <= '0;
    end else begin
      v_q <= v_d;
      e_q <= e_d;
      p_q <= p_d;
      c_q <= c_d;
    end
  end

  assign res_valid = v_q;
  assign res_err   = e_q;
  assign res_pass  = p_q;
  assign res_csum  = c_q;

  // R8: a result and a framing error never appear together
  p_result_excl_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_err));

  // R7: pass only accompanies a valid result
  p_pass_needs_valid_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid);

  // R6: generate mode never reports pass
  p_gen_no_pass_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && (mode_eff == CSUM_GEN)) |=> !res_pass);

endmodule

// File: rtl/desc_csum_unit.sv
module desc_csum_unit
  import desc_csum_pkg::*;
#(
  parameter int NUM_BYTES   = 16,
  parameter int DW          = 8,
  parameter int CSUM_OFFSET = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  input  logic          in_mode,
  output logic          out_valid,
  output logic [DW-1:0] out_csum,
  output logic          out_pass,
  output logic          out_frame_err
);

  localparam int CW = $clog2(NUM_BYTES);

  logic [CW-1:0] beat_idx;
  logic          beat_first, beat_in_frame, frame_good, frame_bad;
  logic [DW-1:0] sum_total, slot_byte;
  csum_mode_e    mode_eff;

  desc_beat_counter #(.NUM_BYTES(NUM_BYTES), .CW(CW)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat_valid    (in_valid),
    .beat_last     (in_last),
    .beat_idx      (beat_idx),
    .beat_first    (beat_first),
    .beat_in_frame (beat_in_frame),
    .frame_good    (frame_good),
    .frame_bad     (frame_bad)
  );

  desc_sum_accum #(.DW(DW), .CW(CW), .CSUM_OFFSET(CSUM_OFFSET)) u_acc (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat_valid    (in_valid),
    .beat_first    (beat_first),
    .beat_in_frame (beat_in_frame),
    .beat_idx      (beat_idx),
    .beat_data     (in_data),
    .beat_mode     (csum_mode_e'(in_mode)),
    .sum_total     (sum_total),
    .slot_byte     (slot_byte),
    .mode_eff      (mode_eff)
  );

  desc_result_stage #(.DW(DW)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_valid  (in_valid && in_last),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .sum_total  (sum_total),
    .slot_byte  (slot_byte),
    .mode_eff   (mode_eff),
    .res_valid  (out_valid),
    .res_csum   (out_csum),
    .res_pass   (out_pass),
    .res_err    (out_frame_err)
  );

  // R1: a terminating beat always yields a result or error next cycle
  p_result_follows_last_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (out_valid || out_frame_err));

  // R1: no result without a terminating beat in the previous cycle
  p_no_spurious_result_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !(out_valid || out_frame_err));

  // R12: csum bus is quiet while no result is presented
  p_quiet_csum_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_csum == '0));

endmodule

// File: tb/desc_csum_unit_bench.sv
`timescale 1ns/1ps
module desc_csum_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_last, in_mode;
  logic [7:0] in_data;
  logic       out_valid, out_pass, out_frame_err;
  logic [7:0] out_csum;

  always #2.5 clk = ~clk;

  desc_csum_unit u_desc_csum_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
    .out_csum(out_csum), .out_pass(out_pass), .out_frame_err(out_frame_err)
  );

  int n_checks = 0;
  int n_err    = 0;
  int seed     = 7;
  logic [7:0] dbuf [0:19];

  // Result monitor: captures each pulse shortly after the clock edge.
  int         res_n = 0;
  logic       r_valid [0:7];
  logic       r_err   [0:7];
  logic       r_pass  [0:7];
  logic [7:0] r_csum  [0:7];

  always @(posedge clk) begin
    #1;
    if (out_valid || out_frame_err) begin
      r_valid[res_n % 8] = out_valid;
      r_err[res_n % 8]   = out_frame_err;
      r_pass[res_n % 8]  = out_pass;
      r_csum[res_n % 8]  = out_csum;
      res_n = res_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 1103515245 + 12345;
    return 8'(seed >>> 16);
  endfunction

  function automatic logic [7:0] model_csum();
    logic [7:0] s = 8'd0;
    for (int i = 0; i < 16; i++) if (i != 1) s = s + dbuf[i];
    s = s + 8'd1;
    return 8'hFF - s;
  endfunction

  // Drives n beats from dbuf; mode on first beat, flipped afterwards if flip.
  task automatic send(input int n, input bit mode, input int gap, input bit flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = dbuf[i];
      in_last  = (i == n - 1);
      in_mode  = (i == 0) ? mode : (mode ^ flip);
      if (gap > 0 && i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_data  = 8'hA5;
          in_last  = 1'b1;
          in_mode  = ~mode;
        end
      end
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // Check the newest result against a good-frame expectation.
  task automatic expect_good(input int base, input bit mode, input string req);
    logic [7:0] e = model_csum();
    int k = (res_n - 1) % 8;
    bit epass = mode && (dbuf[1] == e);
    check(res_n == base + 1, req, res_n - base, 1);
    check(r_valid[k] === 1'b1 && r_err[k] === 1'b0, req, {r_valid[k], r_err[k]}, 2);
    check(r_csum[k] === e, req, r_csum[k], e);
    check(r_pass[k] === epass, req, r_pass[k], epass);
  endtask

  task automatic expect_bad(input int base, input string req);
    int k = (res_n - 1) % 8;
    check(res_n == base + 1, req, res_n - base, 1);
    check(r_err[k] === 1'b1 && r_valid[k] === 1'b0, req, {r_valid[k], r_err[k]}, 1);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 20; i++) dbuf[i] = rnd();
  endtask

  task automatic main_seq();
    int base;
    in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00; in_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs idle under and after reset
    check(out_valid === 1'b0 && out_frame_err === 1'b0, "R11", {out_valid, out_frame_err}, 0);
    check(out_csum === 8'h00 && out_pass === 1'b0, "R11", out_csum, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid === 1'b0 && out_csum === 8'h00, "R11", out_csum, 0);

    // R3 R5 R6: generate-mode sweep, every byte equal to k (mod-256 wrap)
    for (int k = 0; k < 256; k++) begin
      for (int i = 0; i < 16; i++) dbuf[i] = 8'(k);
      base = res_n;
      send(16, 1'b0, 0, 1'b0);
      idle(2);
      expect_good(base, 1'b0, "R3_R5_R6_gen_sweep");
    end

    // R2 R7: check mode, slot byte swept over all 256 values
    fill_random();
    for (int v = 0; v < 256; v++) begin
      dbuf[1] = 8'(v);
      base = res_n;
      send(16, 1'b1, 0, 1'b0);
      idle(2);
      expect_good(base, 1'b1, "R2_R7_slot_sweep");
    end

    // R7: slot holding the correct value passes
    fill_random();
    dbuf[1] = model_csum();
    base = res_n;
    send(16, 1'b1, 0, 1'b0);
    idle(2);
    expect_good(base, 1'b1, "R7_match");
    check(r_pass[(res_n - 1) % 8] === 1'b1, "R7_match", r_pass[(res_n - 1) % 8], 1);

    // R4: bit 0 of byte 0 does not change the constant added
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) dbuf[i] = 8'h00;
      dbuf[0] = 8'(b);
      base = res_n;
      send(16, 1'b0, 0, 1'b0);
      idle(2);
      expect_good(base, 1'b0, "R4_own_bit");
      check(r_csum[(res_n - 1) % 8] === 8'(8'hFE - b), "R4_own_bit",
            r_csum[(res_n - 1) % 8], 8'hFE - b);
    end

    // R6: mode flipping after the first beat is ignored
    for (int m = 0; m < 2; m++) begin
      fill_random();
      dbuf[1] = model_csum();
      base = res_n;
      send(16, m[0], 0, 1'b1);
      idle(2);
      expect_good(base, m[0], "R6_mode_first_beat");
    end

    // R12: idle gaps inside a descriptor
    for (int g = 1; g < 4; g++) begin
      fill_random();
      dbuf[1] = model_csum();
      base = res_n;
      send(16, 1'b1, g, 1'b0);
      idle(2);
      expect_good(base, 1'b1, "R12_gaps");
      idle(3);
      check(out_csum === 8'h00 && out_pass === 1'b0, "R12_quiet", out_csum, 0);
    end

    // R8: short descriptors, then a good one must still work
    for (int n = 1; n < 16; n++) begin
      fill_random();
      base = res_n;
      send(n, 1'b1, 0, 1'b0);
      idle(2);
      expect_bad(base, "R8_short");
      fill_random();
      base = res_n;
      send(16, 1'b0, 0, 1'b0);
      idle(2);
      expect_good(base, 1'b0, "R8_R10_recover");
    end

    // R9: long descriptors
    for (int n = 17; n < 21; n++) begin
      fill_random();
      base = res_n;
      send(n, 1'b0, 0, 1'b0);
      idle(2);
      expect_bad(base, "R9_long");
      fill_random();
      base = res_n;
      send(16, 1'b0, 0, 1'b0);
      idle(2);
      expect_good(base, 1'b0, "R9_R10_recover");
    end

    // R10: back-to-back descriptors with no idle cycle between them
    begin
      logic [7:0] e1;
      fill_random();
      e1 = model_csum();
      base = res_n;
      send(16, 1'b0, 0, 1'b0);
      fill_random();
      send(16, 1'b0, 0, 1'b0);
      idle(2);
      check(res_n == base + 2, "R10_b2b_count", res_n - base, 2);
      check(r_csum[base % 8] === e1, "R10_b2b_first", r_csum[base % 8], e1);
      check(r_csum[(base + 1) % 8] === model_csum(), "R10_b2b_second",
            r_csum[(base + 1) % 8], model_csum());
    end

    // R1: result pulse lasts a single cycle
    fill_random();
    send(16, 1'b0, 0, 1'b0);
    idle(1);
    check(out_valid === 1'b1, "R1_pulse_on", out_valid, 1);
    idle(1);
    check(out_valid === 1'b0, "R1_pulse_off", out_valid, 0);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      main_seq();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule